// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock waveform for an I2C master. A prescaler divides the functional clock into a slower internal time base. Two 16-bit timing words then set how long SCL stays low and how long it stays high, counted in periods of that time base. The bit engine that owns the bus uses the SCL drive level, and also a one-cycle strobe that marks every SCL transition, to place its data changes and samples.

Each timing word holds two 8-bit counts. In standard and fast operation only the lower byte is used. In high-speed operation the lower byte covers the opening phase, which runs at the fast rate, and the upper byte covers the high-speed data phase once the bit engine raises its phase-switch input. A fixed trim, one value for low phases and one for high phases, is added to each count. The software that computes the register values subtracted that trim to cover synchronizer delay, and adding it back restores the intended time.

Configuration is loaded while the block is disabled. Enabling it starts a fresh low phase. Disabling it returns SCL to the released (high) level at once.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted or enable is low, `scl_out` is 1 and `edge_tick` is 0 from the next clock edge onward.
- R2: On the first clock edge at which enable is sampled high after being low, `scl_out` goes to 0 and `edge_tick` pulses for that one cycle.
- R3: Each SCL low phase lasts (L + LO_TRIM) x (prescale + 1) functional clock cycles, where L is the selected byte of `scl_lo_cfg`. With the default parameters LO_TRIM = 7. The prescaler count stays within 0..prescale.
- R4: Each SCL high phase lasts (H + HI_TRIM) x (prescale + 1) functional clock cycles, where H is the selected byte of `scl_hi_cfg`. With the default parameters HI_TRIM = 5.
- R5: `edge_tick` is high for exactly one cycle at each SCL transition made while the block is enabled, and it is never high at any other time.
- R6: When `hs_mode` is 0, bits 7:0 of both timing words are used, whatever the value of `hs_phase`.
- R7: When `hs_mode` is 1, bits 7:0 are used while `hs_phase` is 0 and bits 15:8 are used while `hs_phase` is 1.
- R8: The length of a phase is fixed when that phase begins. A change of `hs_phase` during a phase takes effect from the next SCL transition.
- R9: Deasserting enable in the middle of a phase drives SCL high on the next edge. A later enable starts a complete new low phase.
- R10: The timing words, `prescale` and `hs_mode` may change only while enable is low. `prescale` must be nonzero while enabled. New values take effect from the next enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases SCL high |
| hs_mode | input | 1 | Selects high-speed operation with two-phase counts |
| hs_phase | input | 1 | From the bit engine: 1 selects the high-speed phase counts |
| prescale | input | 8 | Functional clock divider minus one (nonzero) |
| scl_lo_cfg | input | 16 | Low-phase counts: [7:0] first phase, [15:8] high-speed phase |
| scl_hi_cfg | input | 16 | High-phase counts: [7:0] first phase, [15:8] high-speed phase |
| scl_out | output | 1 | SCL drive level |
| edge_tick | output | 1 | One-cycle strobe at each SCL transition |

## Verification
The assertions check on every cycle that the idle level is released, that a strobe appears exactly at the SCL transitions, that the prescaler and phase counters stay within their programmed bounds, and that configuration stays unchanged and legal while the block runs. Phase durations in functional cycles can only be shown by the scenarios. The same holds for choosing the lower or upper count byte under each mode and phase-switch combination, for applying a phase switch only at the next transition, and for restarting cleanly after a disable in the middle of a phase. The scoreboard compares each strobe's level and its spacing from the previous strobe against lengths computed from the programmed counts.

// File: rtl/scl_timing_pkg.sv
// Package: shared widths and defaults for the SCL period generator.
// Assumes counts are byte-wide and the prescaler fits in one byte.
package scl_timing_pkg;
    localparam int SCL_CNT_W   = 8;
    localparam int SCL_PSC_W   = 8;
    localparam int SCL_LO_TRIM = 7;
    localparam int SCL_HI_TRIM = 5;
endpackage

// File: rtl/scl_prescaler.sv
// Module: scl_prescaler
// Divides the functional clock by (prescale + 1) and emits a one-cycle
// internal tick at the end of each division period. Assumes prescale is
// held steady while run is high; run low holds the count at zero.
module scl_prescaler #(
    parameter int PSC_W = scl_timing_pkg::SCL_PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] prescale,
    output logic             itick
);
    logic [PSC_W-1:0] cnt_q;

    assign itick = run && (cnt_q == prescale);

    // Division counter: wraps after reaching prescale, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == prescale) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= prescale));
endmodule

// File: rtl/scl_count_select.sv
// Module: scl_count_select
// Chooses the lower or upper byte of each timing word and adds that
// phase's trim, giving phase lengths in internal ticks. Lane 0 is the
// low phase, lane 1 the high phase. Assumes trims are below 2**CNT_W.
module scl_count_select #(
    parameter int CNT_W   = scl_timing_pkg::SCL_CNT_W,
    parameter int LO_TRIM = scl_timing_pkg::SCL_LO_TRIM,
    parameter int HI_TRIM = scl_timing_pkg::SCL_HI_TRIM,
    localparam int LEN_W  = CNT_W + 1,
    localparam int WORD_W = 2 * CNT_W
) (
    input  logic                       use_upper,
    input  logic [1:0][WORD_W-1:0]     cfg_words,
    output logic [1:0][LEN_W-1:0]      phase_len
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int TRIM_G = (g == 0) ? LO_TRIM : HI_TRIM;
        logic [CNT_W-1:0] cfg_byte;

        // Byte pick: upper half only in the high-speed phase.
        always_comb begin
            cfg_byte = use_upper ? cfg_words[g][WORD_W-1:CNT_W]
                                 : cfg_words[g][CNT_W-1:0];
        end

        assign phase_len[g] = LEN_W'(cfg_byte) + LEN_W'(TRIM_G);
    end
endmodule

// File: rtl/scl_phase_counter.sv
// Module: scl_phase_counter
// Counts internal ticks within the current SCL phase and toggles SCL
// when the phase length is reached. The length is latched at the start
// of each phase. Assumes phase lengths are at least one tick.
module scl_phase_counter #(
    parameter int LEN_W = scl_timing_pkg::SCL_CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             itick,
    input  logic [LEN_W-1:0] lo_len,
    input  logic [LEN_W-1:0] hi_len,
    output logic             active,
    output logic             scl_q,
    output logic             tick_q
);
    logic [LEN_W-1:0] ph_q;
    logic [LEN_W-1:0] len_q;
    logic             phase_done;

    assign phase_done = itick && (ph_q == len_q - LEN_W'(1));

    // Phase sequencer: start low on enable, flip level at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            active <= 1'b0;
            scl_q  <= 1'b1;
            tick_q <= 1'b0;
            ph_q   <= '0;
            len_q  <= '0;
        end else if (!active) begin
            active <= 1'b1;
            scl_q  <= 1'b0;
            tick_q <= 1'b1;
            ph_q   <= '0;
            len_q  <= lo_len;
        end else begin
            tick_q <= 1'b0;
            if (phase_done) begin
                ph_q   <= '0;
                scl_q  <= ~scl_q;
                tick_q <= 1'b1;
                len_q  <= scl_q ? lo_len : hi_len;
            end else if (itick) begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_q && !tick_q));

    // R5
    tick_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> (scl_q != $past(scl_q)));

    // R5
    edge_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (scl_q != $past(scl_q))) |-> tick_q);

    // R4
    ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (ph_q < len_q));
endmodule

// File: rtl/scl_timing_gen.sv
// Module: scl_timing_gen
// Top of the SCL period generator: prescaler, count byte selection and
// phase sequencing. Assumes configuration is written only while enable
// is low and that the bit engine drives hs_phase.
module scl_timing_gen #(
    parameter int CNT_W   = scl_timing_pkg::SCL_CNT_W,
    parameter int PSC_W   = scl_timing_pkg::SCL_PSC_W,
    parameter int LO_TRIM = scl_timing_pkg::SCL_LO_TRIM,
    parameter int HI_TRIM = scl_timing_pkg::SCL_HI_TRIM,
    localparam int LEN_W  = CNT_W + 1,
    localparam int WORD_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs_mode,
    input  logic              hs_phase,
    input  logic [PSC_W-1:0]  prescale,
    input  logic [WORD_W-1:0] scl_lo_cfg,
    input  logic [WORD_W-1:0] scl_hi_cfg,
    output logic              scl_out,
    output logic              edge_tick
);
    logic                  active;
    logic                  itick;
    logic                  use_upper;
    logic [1:0][WORD_W-1:0] cfg_words;
    logic [1:0][LEN_W-1:0]  phase_len;

    assign use_upper    = hs_mode && hs_phase;
    assign cfg_words[0] = scl_lo_cfg;
    assign cfg_words[1] = scl_hi_cfg;

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active && enable),
        .prescale (prescale),
        .itick    (itick)
    );

    scl_count_select #(.CNT_W(CNT_W), .LO_TRIM(LO_TRIM), .HI_TRIM(HI_TRIM)) u_sel (
        .use_upper (use_upper),
        .cfg_words (cfg_words),
        .phase_len (phase_len)
    );

    scl_phase_counter #(.LEN_W(LEN_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .itick  (itick),
        .lo_len (phase_len[0]),
        .hi_len (phase_len[1]),
        .active (active),
        .scl_q  (scl_out),
        .tick_q (edge_tick)
    );

    // R10
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |->
            ($stable(scl_lo_cfg) && $stable(scl_hi_cfg) &&
             $stable(prescale) && $stable(hs_mode)));

    // R10
    psc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (prescale != '0));
endmodule

// File: tb/scl_timing_gen_tb.sv
// Scoreboard bench: the driver task queues the expected SCL edges
// (level and spacing), and the monitor pops one per observed strobe.
module scl_timing_gen_tb_top;
    localparam int LO_TRIM = 7;
    localparam int HI_TRIM = 5;

    typedef struct {
        logic  lvl;
        int    len;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_mode = 1'b0;
    logic        hs_phase = 1'b0;
    logic [7:0]  prescale = 8'd1;
    logic [15:0] scl_lo_cfg = 16'h0101;
    logic [15:0] scl_hi_cfg = 16'h0101;
    logic        scl_out;
    logic        edge_tick;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    int   last_cyc = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    scl_timing_gen #(.LO_TRIM(LO_TRIM), .HI_TRIM(HI_TRIM)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .hs_mode    (hs_mode),
        .hs_phase   (hs_phase),
        .prescale   (prescale),
        .scl_lo_cfg (scl_lo_cfg),
        .scl_hi_cfg (scl_hi_cfg),
        .scl_out    (scl_out),
        .edge_tick  (edge_tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: each strobe must match the next expected edge.
    always @(negedge clk) begin
        if (rst_n && edge_tick) begin
            if (q.size() == 0) begin
                check(1'b0, "R5 unexpected edge_tick", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(scl_out == e.lvl, "R5 level at strobe", int'(scl_out), int'(e.lvl));
                if (e.len > 0)
                    check((cyc - last_cyc) == e.len, e.tag, cyc - last_cyc, e.len);
            end
            last_cyc = cyc;
        end
    end

    function automatic int plen(input int c, input int trim, input int psc);
        return (c + trim) * (psc + 1);
    endfunction

    // Driver: program while disabled, queue expected edges, enable, drain.
    task automatic run_case(input int psc, input int lo, input int hi, input bit hs,
                            input bit ph0, input int sw_at, input int nedge,
                            input string tag);
        bit up0, up1;
        @(negedge clk);
        enable     = 1'b0;
        prescale   = 8'(psc);
        scl_lo_cfg = 16'(lo);
        scl_hi_cfg = 16'(hi);
        hs_mode    = hs;
        hs_phase   = ph0;
        up0 = hs && ph0;
        up1 = hs && (ph0 || (sw_at >= 0));
        q.push_back('{lvl: 1'b0, len: 0, tag: "R2"});
        for (int k = 1; k < nedge; k++) begin
            bit up;
            int c;
            up = (k == 1) ? up0 : up1;
            if ((k % 2) == 1) begin
                c = up ? ((lo >> 8) & 255) : (lo & 255);
                q.push_back('{lvl: 1'b1, len: plen(c, LO_TRIM, psc), tag: {tag, " low length"}});
            end else begin
                c = up ? ((hi >> 8) & 255) : (hi & 255);
                q.push_back('{lvl: 1'b0, len: plen(c, HI_TRIM, psc), tag: {tag, " high length"}});
            end
        end
        @(negedge clk);
        enable = 1'b1;
        if (sw_at >= 0) begin
            repeat (sw_at) @(negedge clk);
            hs_phase = 1'b1;
        end
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        // R9: released high one edge after disable, no strobe
        check(scl_out == 1'b1, "R9 scl after disable", int'(scl_out), 1);
        check(edge_tick == 1'b0, "R9 tick after disable", int'(edge_tick), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(scl_out == 1'b1, "R1 scl in reset", int'(scl_out), 1);
        check(edge_tick == 1'b0, "R1 tick in reset", int'(edge_tick), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: enabled low after reset, still released
        check(scl_out == 1'b1, "R1 scl idle", int'(scl_out), 1);
        check(edge_tick == 1'b0, "R1 tick idle", int'(edge_tick), 0);

        run_case(1, 16'h0302, 16'h0101, 1'b0, 1'b0, -1, 5, "R3R4 standard");
        run_case(1, 16'h0904, 16'h0803, 1'b0, 1'b1, -1, 4, "R6 lower byte");
        run_case(1, 16'h0402, 16'h0301, 1'b1, 1'b0, -1, 4, "R7 first phase");
        run_case(2, 16'h0402, 16'h0301, 1'b1, 1'b1, -1, 4, "R7 hs phase");
        run_case(1, 16'h0502, 16'h0603, 1'b1, 1'b0, 4, 5, "R8 switch");
        run_case(3, 16'h00FF, 16'h0001, 1'b0, 1'b0, -1, 3, "R3 max count");
        run_case(1, 16'h0001, 16'h0001, 1'b0, 1'b0, -1, 4, "R3 min count");
        // R9: disable right after the first edge, mid low phase
        run_case(1, 16'h0003, 16'h0003, 1'b0, 1'b0, -1, 1, "R9 abort");
        run_case(2, 16'h0006, 16'h0002, 1'b0, 1'b0, -1, 4, "R10 new config");

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R5 queue drained", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule